// File: doc/BRIEF.md
# Network-Driven Configuration Loader

This block accepts control cells from a network port and uses them to rebuild a device configuration image. Each data cell carries one image word and a sequence number. The loader keeps only cells that arrive in order, writes each accepted word into an external program memory, and answers every cell with an acknowledge. The sender can then resend anything that was refused. The image counts as loaded only when the cell flagged as last has been accepted in sequence.

Loading and programming are separate steps. A distinct program-command cell makes the loader read the stored image back from memory and stream it, one word per cycle, to the configuration port of a target device. In full mode the loader first pulses an initialise line and waits for the target to report ready. After streaming it waits for a completion signal. In partial mode it skips the initialise pulse and the completion wait, so it only writes frames into the running device while the rest of that device carries on working. A busy flag covers the whole programming run.

Top module: `cfg_loader`

## Requirements
- R1: After reset, busy, load_done, err_count, ack_valid, mem_we, mem_re, cfg_init and cfg_valid are all 0.
- R2: A data cell (cell_kind = 1) accepted while idle produces mem_we = 1 with mem_waddr = cell_seq and mem_wdata = cell_data in the next cycle. In that same cycle ack_valid = 1, ack_ok = 1 and ack_seq = cell_seq.
- R3: A data cell whose sequence number is neither 0 nor the next expected one is dropped. It produces no memory write and an acknowledge with ack_ok = 0, and err_count rises by one.
- R4: An accepted cell with cell_last = 1 sets load_done and records an image length of cell_seq + 1 words. An accepted cell with sequence 0 always restarts a load, and if cell_last is 0 it clears load_done.
- R5: A program cell (cell_kind = 2) is acknowledged with ack_ok = 0 and starts nothing unless load_done = 1 and busy = 0. When it is accepted, busy is 1 in the following cycle.
- R6: In full mode (bit 0 of the program cell's data is 0), cfg_init is high for exactly one cycle, the cycle after acceptance. No cfg_valid appears before cfg_ready has been sampled high.
- R7: Streaming presents stored words 0 to length-1 on cfg_data in address order, with cfg_valid high on consecutive cycles and only while busy.
- R8: In full mode busy stays high after the last word until cfg_done is sampled. In partial mode (bit 0 = 1) cfg_init never rises and busy clears right after the last word.
- R9: While busy, data cells and program cells are refused with ack_ok = 0, and no memory write occurs.
- R10: err_count saturates at its maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_valid | input | 1 | A cell is present this cycle |
| cell_kind | input | 2 | 1 = data cell, 2 = program command, others ignored |
| cell_seq | input | AW | Sequence number of a data cell |
| cell_data | input | DATA_W | Image word, or mode bit 0 for a program command |
| cell_last | input | 1 | Marks the final data cell of an image |
| ack_valid | output | 1 | Acknowledge cell present |
| ack_seq | output | AW | Sequence number being acknowledged |
| ack_ok | output | 1 | 1 = accepted, 0 = refused |
| mem_we | output | 1 | Program memory write enable |
| mem_waddr | output | AW | Write address |
| mem_wdata | output | DATA_W | Write data |
| mem_re | output | 1 | Program memory read enable, one-cycle latency |
| mem_raddr | output | AW | Read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_re |
| cfg_init | output | 1 | Initialise pulse to the target in full mode |
| cfg_ready | input | 1 | Target ready after initialise |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_data | output | DATA_W | Configuration word |
| cfg_done | input | 1 | Target reports configuration complete |
| busy | output | 1 | Programming in progress |
| load_done | output | 1 | A complete image is held in memory |
| err_count | output | ERR_W | Saturating count of out-of-order data cells |

## Verification
The assertions assume that the program memory returns, one cycle after a read strobe, whatever was last written at that address. They also assume the target accepts one configuration word every cycle without stalling. The bench memory model meets both assumptions, and the bench drives the port with no backpressure. The assertions further assume that cfg_ready and cfg_done matter only in their wait states. The bench therefore raises each of them for a single cycle, and only once the loader is waiting for it. Cells are one cycle long and are driven on the falling edge, with at least one idle cycle between them, so every acknowledge can be checked on its own.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_DATA = 2'd1,
    CK_PROG = 2'd2,
    CK_RSVD = 2'd3
  } cell_kind_e;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_WAIT_RDY,
    PS_STREAM,
    PS_DRAIN,
    PS_WAIT_DONE
  } prog_state_e;
endpackage

// File: rtl/cfg_cell_rx.sv
module cfg_cell_rx
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 10,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_valid,
  input  logic [1:0]        cell_kind,
  input  logic [AW-1:0]     cell_seq,
  input  logic [DATA_W-1:0] cell_data,
  input  logic              cell_last,
  input  logic              busy_i,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ack_valid,
  output logic [AW-1:0]     ack_seq,
  output logic              ack_ok,
  output logic [ERR_W-1:0]  err_count,
  output logic              load_done,
  output logic [AW:0]       img_len,
  output logic              prog_go,
  output logic              prog_partial
);
  localparam int LW = AW + 1;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [AW-1:0] exp_seq;
  logic is_data, is_prog, seq_ok, take, seq_err;

  always_comb begin
    is_data      = cell_valid && (cell_kind == CK_DATA);
    is_prog      = cell_valid && (cell_kind == CK_PROG);
    seq_ok       = (cell_seq == exp_seq) || (cell_seq == '0);
    take         = is_data && !busy_i && seq_ok;
    seq_err      = is_data && !busy_i && !seq_ok;
    prog_go      = is_prog && !busy_i && load_done;
    prog_partial = cell_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      ack_valid <= 1'b0;
      ack_seq   <= '0;
      ack_ok    <= 1'b0;
      err_count <= '0;
      load_done <= 1'b0;
      img_len   <= '0;
      exp_seq   <= '0;
    end else begin
      mem_we    <= take;
      mem_waddr <= cell_seq;
      mem_wdata <= cell_data;
      ack_valid <= is_data || is_prog;
      ack_seq   <= cell_seq;
      ack_ok    <= take || prog_go;
      if (take) begin
        load_done <= cell_last;
        if (cell_last) begin
          img_len <= {1'b0, cell_seq} + LW'(1);
          exp_seq <= '0;
        end else begin
          exp_seq <= cell_seq + AW'(1);
        end
      end
      if (seq_err && (err_count != ERR_MAX))
        err_count <= err_count + ERR_W'(1);
    end
  end

  // R9
  write_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(busy_i));

  // R3
  err_step_chk: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) |-> (err_count == $past(err_count) + ERR_W'(1)));

  // R4
  done_len_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (img_len != '0));

  // R2
  ack_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ack_valid && ack_ok && (ack_seq == mem_waddr)));
endmodule

// File: rtl/cfg_prog_stream.sv
module cfg_prog_stream
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_go,
  input  logic              prog_partial,
  input  logic [AW:0]       img_len,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cfg_ready,
  input  logic              cfg_done,
  output logic              busy,
  output logic              mem_re,
  output logic [AW-1:0]     mem_raddr,
  output logic              cfg_init,
  output logic              cfg_valid,
  output logic [DATA_W-1:0] cfg_data
);
  localparam int LW = AW + 1;

  prog_state_e   state;
  logic          partial_q;
  logic [AW-1:0] ptr;
  logic [AW:0]   len_q;
  logic          rd_v1;
  logic          last_rd;

  assign busy    = (state != PS_IDLE);
  assign last_rd = ({1'b0, ptr} == (len_q - LW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_IDLE;
      partial_q <= 1'b0;
      ptr       <= '0;
      len_q     <= '0;
      rd_v1     <= 1'b0;
      mem_re    <= 1'b0;
      mem_raddr <= '0;
      cfg_init  <= 1'b0;
      cfg_valid <= 1'b0;
      cfg_data  <= '0;
    end else begin
      cfg_init  <= 1'b0;
      mem_re    <= 1'b0;
      rd_v1     <= mem_re;
      cfg_valid <= rd_v1;
      if (rd_v1) cfg_data <= mem_rdata;
      unique case (state)
        PS_IDLE: begin
          if (prog_go) begin
            partial_q <= prog_partial;
            len_q     <= img_len;
            ptr       <= '0;
            if (prog_partial) begin
              state <= PS_STREAM;
            end else begin
              cfg_init <= 1'b1;
              state    <= PS_WAIT_RDY;
            end
          end
        end
        PS_WAIT_RDY: if (cfg_ready) state <= PS_STREAM;
        PS_STREAM: begin
          mem_re    <= 1'b1;
          mem_raddr <= ptr;
          ptr       <= ptr + AW'(1);
          if (last_rd) state <= PS_DRAIN;
        end
        PS_DRAIN: begin
          if (!mem_re && !rd_v1)
            state <= partial_q ? PS_IDLE : PS_WAIT_DONE;
        end
        PS_WAIT_DONE: if (cfg_done) state <= PS_IDLE;
        default: state <= PS_IDLE;
      endcase
    end
  end

  // R6
  init_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_init |=> !cfg_init);

  // R8
  partial_no_init_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_init |-> !partial_q);

  // R7
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> busy);

  // R5
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(prog_go));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 10,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_valid,
  input  logic [1:0]        cell_kind,
  input  logic [AW-1:0]     cell_seq,
  input  logic [DATA_W-1:0] cell_data,
  input  logic              cell_last,
  output logic              ack_valid,
  output logic [AW-1:0]     ack_seq,
  output logic              ack_ok,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic [AW-1:0]     mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cfg_init,
  input  logic              cfg_ready,
  output logic              cfg_valid,
  output logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_done,
  output logic              busy,
  output logic              load_done,
  output logic [ERR_W-1:0]  err_count
);
  logic          prog_go;
  logic          prog_partial;
  logic [AW:0]   img_len;

  cfg_cell_rx #(.DATA_W(DATA_W), .AW(AW), .ERR_W(ERR_W)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .cell_valid   (cell_valid),
    .cell_kind    (cell_kind),
    .cell_seq     (cell_seq),
    .cell_data    (cell_data),
    .cell_last    (cell_last),
    .busy_i       (busy),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr),
    .mem_wdata    (mem_wdata),
    .ack_valid    (ack_valid),
    .ack_seq      (ack_seq),
    .ack_ok       (ack_ok),
    .err_count    (err_count),
    .load_done    (load_done),
    .img_len      (img_len),
    .prog_go      (prog_go),
    .prog_partial (prog_partial)
  );

  cfg_prog_stream #(.DATA_W(DATA_W), .AW(AW)) u_stream (
    .clk          (clk),
    .rst          (rst),
    .prog_go      (prog_go),
    .prog_partial (prog_partial),
    .img_len      (img_len),
    .mem_rdata    (mem_rdata),
    .cfg_ready    (cfg_ready),
    .cfg_done     (cfg_done),
    .busy         (busy),
    .mem_re       (mem_re),
    .mem_raddr    (mem_raddr),
    .cfg_init     (cfg_init),
    .cfg_valid    (cfg_valid),
    .cfg_data     (cfg_data)
  );

  // R1
  idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cfg_init);
endmodule

// File: tb/cfg_loader_tb.sv
`timescale 1ns/100ps
module cfg_loader_tb;
  localparam int DW = 8, AW = 4, EW = 3, DEPTH = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic cell_valid = 1'b0, cell_last = 1'b0;
  logic [1:0] cell_kind = '0;
  logic [AW-1:0] cell_seq = '0;
  logic [DW-1:0] cell_data = '0;
  logic ack_valid, ack_ok, mem_we, mem_re, cfg_init, cfg_valid, busy, load_done;
  logic [AW-1:0] ack_seq, mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, cfg_data;
  logic [DW-1:0] mem_rdata = '0;
  logic cfg_ready = 1'b0, cfg_done = 1'b0;
  logic [EW-1:0] err_count;

  cfg_loader #(.DATA_W(DW), .AW(AW), .ERR_W(EW)) u_dut (
    .clk(clk), .rst(rst), .cell_valid(cell_valid), .cell_kind(cell_kind),
    .cell_seq(cell_seq), .cell_data(cell_data), .cell_last(cell_last),
    .ack_valid(ack_valid), .ack_seq(ack_seq), .ack_ok(ack_ok),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .cfg_init(cfg_init), .cfg_ready(cfg_ready), .cfg_valid(cfg_valid),
    .cfg_data(cfg_data), .cfg_done(cfg_done), .busy(busy),
    .load_done(load_done), .err_count(err_count)
  );

  logic [DW-1:0] pmem [DEPTH];
  always @(posedge clk) begin
    if (mem_we) pmem[mem_waddr] <= mem_wdata;
    if (mem_re) mem_rdata <= pmem[mem_raddr];
  end

  int vecs = 0, errs = 0;
  logic [DW-1:0] exp_img [DEPTH];
  int str_idx = 0, str_len = 0, gaps = 0, inits = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] img_a(input int s);
    return DW'((s * 37 + 11) & 255);
  endfunction
  function automatic logic [DW-1:0] img_b(input int s);
    return DW'((s * 13 + 200) & 255);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (cfg_init) inits++;
      if (cfg_valid) begin
        if (str_idx < DEPTH)
          chk(cfg_data == exp_img[str_idx], "R7 word", int'(cfg_data), int'(exp_img[str_idx]));
        str_idx++;
      end else if (str_idx > 0 && str_idx < str_len) begin
        gaps++;
      end
    end
  end

  task automatic send(input logic [1:0] k, input int s, input logic [DW-1:0] d, input bit last);
    @(negedge clk);
    cell_valid = 1'b1; cell_kind = k; cell_seq = AW'(s); cell_data = d; cell_last = last;
    @(negedge clk);
    cell_valid = 1'b0; cell_last = 1'b0;
  endtask

  task automatic load_word(input int s, input logic [DW-1:0] d, input bit last, input bit good, input string req);
    send(2'd1, s, d, last);
    chk(ack_valid && ack_seq == AW'(s), req, int'(ack_seq), s);
    chk(ack_ok == good, req, int'(ack_ok), int'(good));
    chk(mem_we == good, req, int'(mem_we), int'(good));
    if (good) chk(mem_waddr == AW'(s) && mem_wdata == d, req, int'(mem_wdata), int'(d));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !load_done && err_count == 0, "R1", int'(busy), 0);
    chk(!ack_valid && !mem_we && !mem_re && !cfg_init && !cfg_valid, "R1 outs", int'(cfg_valid), 0);

    // R5 program refused with no image
    send(2'd2, 0, 8'd0, 0);
    chk(ack_valid && !ack_ok, "R5 no image", int'(ack_ok), 0);
    @(negedge clk);
    chk(!busy, "R5 busy", int'(busy), 0);

    // Image A: 16 words with injected ordering faults (R2 R3 R4)
    load_word(0, img_a(0), 0, 1, "R2");
    chk(!load_done, "R4 not yet", int'(load_done), 0);
    load_word(1, img_a(1), 0, 1, "R2");
    load_word(3, img_a(3), 0, 0, "R3 skip");
    chk(err_count == 1, "R3 count", int'(err_count), 1);
    load_word(2, img_a(2), 0, 1, "R2");
    load_word(2, img_a(2), 0, 0, "R3 dup");
    chk(err_count == 2, "R3 count", int'(err_count), 2);
    for (int s = 3; s < DEPTH; s++) load_word(s, img_a(s), s == DEPTH - 1, 1, "R2 sweep");
    chk(load_done, "R4 done", int'(load_done), 1);

    // Full-mode programming
    for (int i = 0; i < DEPTH; i++) exp_img[i] = img_a(i);
    str_idx = 0; str_len = DEPTH; gaps = 0; inits = 0;
    send(2'd2, 0, 8'd0, 0);
    chk(ack_ok && busy, "R5 accept", int'(busy), 1);
    chk(cfg_init, "R6 init", int'(cfg_init), 1);
    @(negedge clk);
    chk(!cfg_init, "R6 pulse width", int'(cfg_init), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!cfg_valid, "R6 wait ready", int'(cfg_valid), 0);
    end
    // R9 refusal while busy
    load_word(0, 8'h55, 0, 0, "R9 data");
    send(2'd2, 0, 8'd0, 0);
    chk(ack_valid && !ack_ok, "R9 prog", int'(ack_ok), 0);
    chk(str_idx == 0, "R6 no data", str_idx, 0);
    cfg_ready = 1'b1;
    @(negedge clk);
    cfg_ready = 1'b0;
    for (int t = 0; t < 200 && str_idx < str_len; t++) @(negedge clk);
    chk(str_idx == DEPTH, "R7 count", str_idx, DEPTH);
    chk(gaps == 0, "R7 gaps", gaps, 0);
    chk(inits == 1, "R6 inits", inits, 1);
    repeat (4) begin
      @(negedge clk);
      chk(busy, "R8 wait done", int'(busy), 1);
    end
    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    chk(!busy, "R8 done", int'(busy), 0);
    chk(str_idx == DEPTH, "R7 no extra", str_idx, DEPTH);

    // Image B: 5 words, restart from seq 0 (R4)
    load_word(0, img_b(0), 0, 1, "R4 restart");
    chk(!load_done, "R4 cleared", int'(load_done), 0);
    for (int s = 1; s < 5; s++) load_word(s, img_b(s), s == 4, 1, "R2 image b");
    chk(load_done, "R4 done b", int'(load_done), 1);

    // Partial-mode programming
    for (int i = 0; i < 5; i++) exp_img[i] = img_b(i);
    str_idx = 0; str_len = 5; gaps = 0; inits = 0;
    send(2'd2, 0, 8'd1, 0);
    chk(ack_ok && busy, "R5 accept partial", int'(busy), 1);
    chk(!cfg_init, "R8 no init", int'(cfg_init), 0);
    for (int t = 0; t < 200 && str_idx < str_len; t++) @(negedge clk);
    @(negedge clk);
    chk(str_idx == 5, "R7 count b", str_idx, 5);
    chk(gaps == 0, "R7 gaps b", gaps, 0);
    chk(inits == 0, "R8 inits", inits, 0);
    chk(!busy, "R8 partial release", int'(busy), 0);

    // R10 saturation of the error counter
    for (int k = 1; k <= 6; k++) begin
      load_word(7, 8'h00, 0, 0, "R3 late");
      chk(err_count == EW'((2 + k > 7) ? 7 : 2 + k), "R10", int'(err_count), (2 + k > 7) ? 7 : 2 + k);
    end
    chk(load_done, "R4 kept", int'(load_done), 1);

    finished = 1;
    summary();
  end
endmodule